// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block chooses where each execute-stage operand of a five-stage integer pipeline comes from. It takes the register fields and the instruction class held in three pipeline registers: decode-to-execute, execute-to-memory and memory-to-writeback. It works out which of the two older instructions writes a register, and compares that destination with the sources of the younger instructions. From this it produces select codes for the two ALU operand multiplexers and for the store-data multiplexer that feeds data memory.

There are three bypass sources for an ALU operand:
- the ALU result held in the execute-to-memory register;
- the ALU result held in the memory-to-writeback register;
- the loaded word held in the memory-to-writeback register.

A separate path carries a loaded word straight into the write data of a store in the memory stage. That path covers a load followed at once by a store of the same register.

The datapath multiplexers are included, so the block also returns the chosen operand values. The logic is purely combinational. Stall insertion for a load followed at once by a consumer, and branch resolution, belong to neighbouring logic.

Top module: `fwd_unit`

## Requirements
- R1: The class code is 3 bits: 0 no-op, 1 register-register ALU, 2 register-immediate ALU, 3 load, 4 store, 5 branch; codes 6 and 7 are treated like a no-op. A class 1 instruction writes its rd field, classes 2 and 3 write their rt field, and all other classes write no register.
- R2: Each ALU operand select is 2 bits: 00 register-file value, 01 execute-to-memory ALU result, 10 memory-to-writeback ALU result, 11 memory-to-writeback loaded word.
- R3: When both the execute-to-memory and the memory-to-writeback destinations match an operand's source, the execute-to-memory result (select 01) wins.
- R4: A source or destination equal to register 0 never produces a bypass.
- R5: A load in the execute-to-memory register is never a bypass source, because its ALU result is an address; a matching memory-to-writeback writer may still be selected.
- R6: Operand A compares the decode-to-execute rs field and is used by classes 1 to 5. Operand B compares its rt field and is used only by classes 1 and 4. An unused operand selects 00.
- R7: The 1-bit store-data select is 1 exactly when execute-to-memory holds a store and memory-to-writeback holds a load, and the load's rt is nonzero and equal to the store's rt. Otherwise it is 0, which selects the store data carried in the pipeline.
- R8: alu_a, alu_b and store_wdata equal the source chosen by sel_a, sel_b and sel_store in the same cycle, with no register in between.
- R9: A memory-to-writeback match selects 11 when that instruction is a load and 10 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idex_cls | input | 3 | Class of the instruction in decode-to-execute |
| idex_rs | input | REG_AW | rs field in decode-to-execute |
| idex_rt | input | REG_AW | rt field in decode-to-execute |
| exmem_cls | input | 3 | Class of the instruction in execute-to-memory |
| exmem_rt | input | REG_AW | rt field in execute-to-memory |
| exmem_rd | input | REG_AW | rd field in execute-to-memory |
| memwb_cls | input | 3 | Class of the instruction in memory-to-writeback |
| memwb_rt | input | REG_AW | rt field in memory-to-writeback |
| memwb_rd | input | REG_AW | rd field in memory-to-writeback |
| rf_a_data | input | DATA_W | Register-file value for operand A |
| rf_b_data | input | DATA_W | Register-file value for operand B |
| exmem_alu_data | input | DATA_W | ALU result in execute-to-memory |
| memwb_alu_data | input | DATA_W | ALU result in memory-to-writeback |
| memwb_lmd_data | input | DATA_W | Loaded word in memory-to-writeback |
| exmem_store_data | input | DATA_W | Store data carried in execute-to-memory |
| sel_a | output | 2 | Operand A select code |
| sel_b | output | 2 | Operand B select code |
| sel_store | output | 1 | Store-data select |
| alu_a | output | DATA_W | Chosen operand A |
| alu_b | output | DATA_W | Chosen operand B |
| store_wdata | output | DATA_W | Chosen memory write data |

## Verification
The bench uses 4 registers. It sweeps every pairing of the six classes across the three stages, with every combination of source and destination register numbers. This separates a match in one stage from a match in both, a match on register 0 from a match on any other register, and the correct destination field from the unused one. For the field that a class does not write, the bench places a register number that differs from the real destination, so reading the wrong field changes the outcome. Each sweep pattern also carries distinct data words on every source, so a wrong multiplexer leg shows up at the data outputs even when the select code is right. Directed patterns then isolate each priority rule and the unused class codes.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

   typedef enum logic [2:0] {
      CLS_NOP    = 3'd0,
      CLS_RR     = 3'd1,
      CLS_RI     = 3'd2,
      CLS_LOAD   = 3'd3,
      CLS_STORE  = 3'd4,
      CLS_BRANCH = 3'd5
   } op_class_e;

   localparam int CLS_W = 3;

   localparam logic [1:0] SEL_RF      = 2'b00;
   localparam logic [1:0] SEL_EXM_ALU = 2'b01;
   localparam logic [1:0] SEL_MWB_ALU = 2'b10;
   localparam logic [1:0] SEL_MWB_LMD = 2'b11;

   function automatic logic cls_reads_rs(input logic [CLS_W-1:0] cls);
      return (cls == CLS_RR) || (cls == CLS_RI) || (cls == CLS_LOAD) ||
             (cls == CLS_STORE) || (cls == CLS_BRANCH);
   endfunction

   function automatic logic cls_reads_rt(input logic [CLS_W-1:0] cls);
      return (cls == CLS_RR) || (cls == CLS_STORE);
   endfunction

endpackage

// File: rtl/fwd_dest_decode.sv
module fwd_dest_decode
   import fwd_pkg::*;
#(
   parameter int REG_AW = 5
) (
   input  logic [CLS_W-1:0]  cls,
   input  logic [REG_AW-1:0] rt,
   input  logic [REG_AW-1:0] rd,
   output logic              wr_en,
   output logic [REG_AW-1:0] dest
);

   always_comb begin
      wr_en = 1'b0;
      dest  = '0;
      case (cls)
         CLS_RR: begin
            wr_en = 1'b1;
            dest  = rd;
         end
         CLS_RI, CLS_LOAD: begin
            wr_en = 1'b1;
            dest  = rt;
         end
         default: begin
            wr_en = 1'b0;
            dest  = '0;
         end
      endcase
   end

   // R1: stores, branches and no-ops never claim a destination
   always_comb begin
      assert_writer_class_R1: assert (!wr_en || cls == CLS_RR || cls == CLS_RI || cls == CLS_LOAD)
         else $error("writer flagged for a non-writing class");
   end

endmodule

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel
   import fwd_pkg::*;
#(
   parameter int REG_AW = 5
) (
   input  logic              used,
   input  logic [REG_AW-1:0] src,
   input  logic              exm_wr,
   input  logic [REG_AW-1:0] exm_dest,
   input  logic              exm_is_load,
   input  logic              mwb_wr,
   input  logic [REG_AW-1:0] mwb_dest,
   input  logic              mwb_is_load,
   output logic [1:0]        sel
);

   logic src_live;
   logic exm_hit;
   logic mwb_hit;

   assign src_live = used && (src != '0);
   assign exm_hit  = src_live && exm_wr && !exm_is_load && (exm_dest == src);
   assign mwb_hit  = src_live && mwb_wr && (mwb_dest == src);

   always_comb begin
      if (exm_hit)
         sel = SEL_EXM_ALU;
      else if (mwb_hit)
         sel = mwb_is_load ? SEL_MWB_LMD : SEL_MWB_ALU;
      else
         sel = SEL_RF;
   end

   always_comb begin
      assert_no_zero_bypass_R4: assert (src != '0 || sel == SEL_RF)
         else $error("bypass selected for register 0");
      assert_unused_operand_R6: assert (used || sel == SEL_RF)
         else $error("bypass selected for an unused operand");
      assert_no_load_addr_R5: assert (sel != SEL_EXM_ALU || !exm_is_load)
         else $error("load address forwarded as data");
      assert_younger_first_R3: assert (sel[1] == 1'b0 ||
                                       !(exm_wr && !exm_is_load && exm_dest == src))
         else $error("older result chosen over younger match");
      assert_lmd_only_load_R9: assert (sel != SEL_MWB_LMD || mwb_is_load)
         else $error("loaded word chosen for a non-load");
   end

endmodule

// File: rtl/fwd_store_sel.sv
module fwd_store_sel
   import fwd_pkg::*;
#(
   parameter int REG_AW       = 5,
   parameter bit LOAD_TO_STORE = 1'b1
) (
   input  logic [CLS_W-1:0]  exm_cls,
   input  logic [REG_AW-1:0] exm_rt,
   input  logic              mwb_is_load,
   input  logic [REG_AW-1:0] mwb_dest,
   output logic              sel_store
);

   generate
      if (LOAD_TO_STORE) begin : g_path
         assign sel_store = (exm_cls == CLS_STORE) && mwb_is_load &&
                            (mwb_dest != '0) && (mwb_dest == exm_rt);
      end else begin : g_nopath
         logic unused_in;
         assign unused_in = ^{exm_cls, exm_rt, mwb_is_load, mwb_dest};
         assign sel_store = 1'b0;
      end
   endgenerate

   // R7: the path only opens between a store and an older load
   always_comb begin
      assert_store_pair_R7: assert (!sel_store || (exm_cls == CLS_STORE && mwb_is_load))
         else $error("store-data bypass outside a load/store pair");
   end

endmodule

// File: rtl/fwd_bypass_mux.sv
module fwd_bypass_mux #(
   parameter int DATA_W    = 32,
   parameter int MUX_STYLE = 0
) (
   input  logic [1:0]        sel,
   input  logic [DATA_W-1:0] d_rf,
   input  logic [DATA_W-1:0] d_exm_alu,
   input  logic [DATA_W-1:0] d_mwb_alu,
   input  logic [DATA_W-1:0] d_mwb_lmd,
   output logic [DATA_W-1:0] q
);

   generate
      if (MUX_STYLE == 0) begin : g_case
         always_comb begin
            case (sel)
               2'b01:   q = d_exm_alu;
               2'b10:   q = d_mwb_alu;
               2'b11:   q = d_mwb_lmd;
               default: q = d_rf;
            endcase
         end
      end else begin : g_andor
         assign q = ({DATA_W{sel == 2'b00}} & d_rf)      |
                    ({DATA_W{sel == 2'b01}} & d_exm_alu) |
                    ({DATA_W{sel == 2'b10}} & d_mwb_alu) |
                    ({DATA_W{sel == 2'b11}} & d_mwb_lmd);
      end
   endgenerate

   always_comb begin
      assert_mux_lmd_R8: assert (sel != 2'b11 || q == d_mwb_lmd)
         else $error("loaded-word leg not passed");
      assert_mux_rf_R8: assert (sel != 2'b00 || q == d_rf)
         else $error("register-file leg not passed");
   end

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
   import fwd_pkg::*;
#(
   parameter int REG_AW        = 5,
   parameter int DATA_W        = 32,
   parameter int MUX_STYLE     = 0,
   parameter bit LOAD_TO_STORE = 1'b1
) (
   input  logic [2:0]        idex_cls,
   input  logic [REG_AW-1:0] idex_rs,
   input  logic [REG_AW-1:0] idex_rt,
   input  logic [2:0]        exmem_cls,
   input  logic [REG_AW-1:0] exmem_rt,
   input  logic [REG_AW-1:0] exmem_rd,
   input  logic [2:0]        memwb_cls,
   input  logic [REG_AW-1:0] memwb_rt,
   input  logic [REG_AW-1:0] memwb_rd,
   input  logic [DATA_W-1:0] rf_a_data,
   input  logic [DATA_W-1:0] rf_b_data,
   input  logic [DATA_W-1:0] exmem_alu_data,
   input  logic [DATA_W-1:0] memwb_alu_data,
   input  logic [DATA_W-1:0] memwb_lmd_data,
   input  logic [DATA_W-1:0] exmem_store_data,
   output logic [1:0]        sel_a,
   output logic [1:0]        sel_b,
   output logic              sel_store,
   output logic [DATA_W-1:0] alu_a,
   output logic [DATA_W-1:0] alu_b,
   output logic [DATA_W-1:0] store_wdata
);

   localparam int NUM_OPS = 2;

   generate
      if (REG_AW < 1 || REG_AW > 8) begin : g_bad_aw
         $error("REG_AW must lie in 1..8");
      end
      if (DATA_W < 1) begin : g_bad_dw
         $error("DATA_W must be positive");
      end
      if (MUX_STYLE != 0 && MUX_STYLE != 1) begin : g_bad_style
         $error("MUX_STYLE must be 0 or 1");
      end
   endgenerate

   logic              exm_wr, mwb_wr;
   logic [REG_AW-1:0] exm_dest, mwb_dest;
   logic              exm_is_load, mwb_is_load;

   assign exm_is_load = (exmem_cls == CLS_LOAD);
   assign mwb_is_load = (memwb_cls == CLS_LOAD);

   fwd_dest_decode #(.REG_AW(REG_AW)) u_exm_dest (
      .cls(exmem_cls), .rt(exmem_rt), .rd(exmem_rd), .wr_en(exm_wr), .dest(exm_dest)
   );

   fwd_dest_decode #(.REG_AW(REG_AW)) u_mwb_dest (
      .cls(memwb_cls), .rt(memwb_rt), .rd(memwb_rd), .wr_en(mwb_wr), .dest(mwb_dest)
   );

   logic [NUM_OPS-1:0]             op_used;
   logic [NUM_OPS-1:0][REG_AW-1:0] op_src;
   logic [NUM_OPS-1:0][1:0]        op_sel;
   logic [NUM_OPS-1:0][DATA_W-1:0] op_rf;
   logic [NUM_OPS-1:0][DATA_W-1:0] op_q;

   assign op_used[0] = cls_reads_rs(idex_cls);
   assign op_used[1] = cls_reads_rt(idex_cls);
   assign op_src[0]  = idex_rs;
   assign op_src[1]  = idex_rt;
   assign op_rf[0]   = rf_a_data;
   assign op_rf[1]   = rf_b_data;

   generate
      for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
         fwd_operand_sel #(.REG_AW(REG_AW)) u_sel (
            .used(op_used[i]),
            .src(op_src[i]),
            .exm_wr(exm_wr),
            .exm_dest(exm_dest),
            .exm_is_load(exm_is_load),
            .mwb_wr(mwb_wr),
            .mwb_dest(mwb_dest),
            .mwb_is_load(mwb_is_load),
            .sel(op_sel[i])
         );

         fwd_bypass_mux #(.DATA_W(DATA_W), .MUX_STYLE(MUX_STYLE)) u_mux (
            .sel(op_sel[i]),
            .d_rf(op_rf[i]),
            .d_exm_alu(exmem_alu_data),
            .d_mwb_alu(memwb_alu_data),
            .d_mwb_lmd(memwb_lmd_data),
            .q(op_q[i])
         );
      end
   endgenerate

   fwd_store_sel #(.REG_AW(REG_AW), .LOAD_TO_STORE(LOAD_TO_STORE)) u_store (
      .exm_cls(exmem_cls),
      .exm_rt(exmem_rt),
      .mwb_is_load(mwb_is_load),
      .mwb_dest(mwb_dest),
      .sel_store(sel_store)
   );

   assign sel_a       = op_sel[0];
   assign sel_b       = op_sel[1];
   assign alu_a       = op_q[0];
   assign alu_b       = op_q[1];
   assign store_wdata = sel_store ? memwb_lmd_data : exmem_store_data;

   // R8: the store-data leg follows its select
   always_comb begin
      assert_store_leg_R8: assert (sel_store ? (store_wdata == memwb_lmd_data)
                                             : (store_wdata == exmem_store_data))
         else $error("store write data does not follow its select");
   end

endmodule

// File: tb/fwd_unit_tb.sv
module fwd_unit_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int AW         = 2;
   localparam int DW         = 16;
   localparam int WATCHDOG   = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic [2:0]    idex_cls, exmem_cls, memwb_cls;
   logic [AW-1:0] idex_rs, idex_rt, exmem_rt, exmem_rd, memwb_rt, memwb_rd;
   logic [DW-1:0] rf_a_data, rf_b_data, exmem_alu_data, memwb_alu_data, memwb_lmd_data, exmem_store_data;
   logic [1:0]    sel_a, sel_b;
   logic          sel_store;
   logic [DW-1:0] alu_a, alu_b, store_wdata;

   fwd_unit #(.REG_AW(AW), .DATA_W(DW)) dut_i (
      .idex_cls(idex_cls), .idex_rs(idex_rs), .idex_rt(idex_rt),
      .exmem_cls(exmem_cls), .exmem_rt(exmem_rt), .exmem_rd(exmem_rd),
      .memwb_cls(memwb_cls), .memwb_rt(memwb_rt), .memwb_rd(memwb_rd),
      .rf_a_data(rf_a_data), .rf_b_data(rf_b_data),
      .exmem_alu_data(exmem_alu_data), .memwb_alu_data(memwb_alu_data),
      .memwb_lmd_data(memwb_lmd_data), .exmem_store_data(exmem_store_data),
      .sel_a(sel_a), .sel_b(sel_b), .sel_store(sel_store),
      .alu_a(alu_a), .alu_b(alu_b), .store_wdata(store_wdata)
   );

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   task automatic chk(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // R1 destination model
   function automatic int dest_of(input int c, input int rt, input int rd);
      if (c == 1) return rd;
      if (c == 2 || c == 3) return rt;
      return -1;
   endfunction

   // R2 R3 R4 R5 R9 select model
   function automatic int exp_sel(input bit used, input int src,
                                  input int ec, input int ert, input int erd,
                                  input int mc, input int mrt, input int mrd);
      int ed, md;
      if (!used || src == 0) return 0;
      ed = dest_of(ec, ert, erd);
      if (ec != 3 && ed == src) return 1;
      md = dest_of(mc, mrt, mrd);
      if (md == src) return (mc == 3) ? 3 : 2;
      return 0;
   endfunction

   function automatic int pick(input int s, input int rf, input int e, input int m, input int l);
      case (s)
         1: return e;
         2: return m;
         3: return l;
         default: return rf;
      endcase
   endfunction

   task automatic apply(input int ic, input int irs, input int irt,
                        input int ec, input int ert, input int erd,
                        input int mc, input int mrt, input int mrd, input int seed);
      @(negedge clk);
      idex_cls  = 3'(ic);  idex_rs  = AW'(irs); idex_rt  = AW'(irt);
      exmem_cls = 3'(ec);  exmem_rt = AW'(ert); exmem_rd = AW'(erd);
      memwb_cls = 3'(mc);  memwb_rt = AW'(mrt); memwb_rd = AW'(mrd);
      rf_a_data        = DW'(16'hA001 ^ seed);
      rf_b_data        = DW'(16'hB002 ^ seed);
      exmem_alu_data   = DW'(16'hC003 ^ seed);
      memwb_alu_data   = DW'(16'hD004 ^ seed);
      memwb_lmd_data   = DW'(16'hE005 ^ seed);
      exmem_store_data = DW'(16'hF006 ^ seed);
      #2;
   endtask

   initial begin
      idex_cls = '0; idex_rs = '0; idex_rt = '0;
      exmem_cls = '0; exmem_rt = '0; exmem_rd = '0;
      memwb_cls = '0; memwb_rt = '0; memwb_rd = '0;
      rf_a_data = '0; rf_b_data = '0; exmem_alu_data = '0;
      memwb_alu_data = '0; memwb_lmd_data = '0; exmem_store_data = '0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      // reset state: all no-ops select the register file (R2)
      apply(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      chk("R2 idle sel_a", sel_a, 0);
      chk("R2 idle sel_b", sel_b, 0);
      chk("R7 idle sel_store", sel_store, 0);

      // R1: immediate writes rt, reg-reg writes rd, class 7 writes none
      apply(1, 1, 2, 2, 1, 3, 0, 0, 0, 1);
      chk("R1 ri dest rt", sel_a, 1);
      apply(1, 1, 2, 1, 1, 3, 0, 0, 0, 2);
      chk("R1 rr dest rd", sel_a, 0);
      apply(1, 1, 2, 7, 1, 1, 7, 2, 2, 3);
      chk("R1 code 7 exm", sel_a, 0);
      chk("R1 code 7 mwb", sel_b, 0);

      // R3: younger wins
      apply(1, 1, 2, 1, 0, 1, 1, 0, 1, 4);
      chk("R3 both match", sel_a, 1);
      chk("R8 alu_a younger data", alu_a, 16'hC003 ^ 4);

      // R4: register 0
      apply(1, 0, 0, 1, 0, 0, 2, 0, 0, 5);
      chk("R4 zero src a", sel_a, 0);
      chk("R4 zero src b", sel_b, 0);

      // R5: load in execute-to-memory skipped, older writer used
      apply(1, 1, 2, 3, 1, 0, 0, 0, 0, 6);
      chk("R5 exm load", sel_a, 0);
      apply(1, 1, 2, 3, 1, 0, 1, 0, 1, 7);
      chk("R5 fall to mwb", sel_a, 2);

      // R6: immediate class ignores rt, store uses rt
      apply(2, 1, 2, 0, 0, 0, 1, 0, 2, 8);
      chk("R6 ri no b", sel_b, 0);
      chk("R6 ri b data", alu_b, 16'hB002 ^ 8);
      apply(4, 1, 2, 0, 0, 0, 1, 0, 2, 9);
      chk("R6 store b", sel_b, 2);

      // R9: load in memory-to-writeback gives loaded word
      apply(1, 1, 3, 0, 0, 0, 3, 3, 0, 10);
      chk("R9 lmd sel", sel_b, 3);
      chk("R8 lmd data", alu_b, 16'hE005 ^ 10);

      // R7: load then store of same register
      apply(0, 0, 0, 4, 2, 0, 3, 2, 0, 11);
      chk("R7 load-store", sel_store, 1);
      chk("R8 store data lmd", store_wdata, 16'hE005 ^ 11);
      apply(0, 0, 0, 4, 2, 0, 2, 2, 0, 12);
      chk("R7 alu-store", sel_store, 0);
      chk("R8 store data pipe", store_wdata, 16'hF006 ^ 12);
      apply(0, 0, 0, 4, 0, 0, 3, 0, 0, 13);
      chk("R7 reg 0", sel_store, 0);

      // sweep of classes 0..5 at all stages and all register numbers
      for (int ic = 0; ic < 6; ic++)
         for (int ec = 0; ec < 6; ec++)
            for (int mc = 0; mc < 6; mc++)
               for (int v = 0; v < 256; v++) begin
                  int rs, rt, ed, md, ert, erd, mrt, mrd, sa, sb, ss, seed;
                  bit ua, ub;
                  rs = v & 3; rt = (v >> 2) & 3; ed = (v >> 4) & 3; md = (v >> 6) & 3;
                  if (ec == 1) begin erd = ed; ert = ed ^ 1; end
                  else         begin ert = ed; erd = ed ^ 1; end
                  if (mc == 1) begin mrd = md; mrt = md ^ 1; end
                  else         begin mrt = md; mrd = md ^ 1; end
                  seed = (v * 37 + ic * 5 + ec * 11 + mc * 3) & 16'h0FF0;
                  apply(ic, rs, rt, ec, ert, erd, mc, mrt, mrd, seed);
                  ua = (ic >= 1 && ic <= 5);
                  ub = (ic == 1 || ic == 4);
                  sa = exp_sel(ua, rs, ec, ert, erd, mc, mrt, mrd);
                  sb = exp_sel(ub, rt, ec, ert, erd, mc, mrt, mrd);
                  ss = (ec == 4 && mc == 3 && mrt != 0 && mrt == ert) ? 1 : 0;
                  chk("R6 sweep sel_a", sel_a, sa);
                  chk("R6 sweep sel_b", sel_b, sb);
                  chk("R7 sweep sel_store", sel_store, ss);
                  chk("R8 sweep alu_a", alu_a,
                      pick(sa, 16'hA001 ^ seed, 16'hC003 ^ seed, 16'hD004 ^ seed, 16'hE005 ^ seed));
                  chk("R8 sweep alu_b", alu_b,
                      pick(sb, 16'hB002 ^ seed, 16'hC003 ^ seed, 16'hD004 ^ seed, 16'hE005 ^ seed));
                  chk("R8 sweep store_wdata", store_wdata,
                      ss ? (16'hE005 ^ seed) : (16'hF006 ^ seed));
               end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

endmodule